// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block is the receive side of a stereo serial audio link on which it is always the slave. It takes the frame clock, the bit clock and the serial data line as inputs and never drives a clock. It recovers one left and one right sample per frame. Three framings are available: I²S, Left-Justified and Right-Justified. The sample word length can be set from 1 up to the parameter `WORD_W`.

All capture logic runs on the bit clock. A completed left/right pair crosses to the system clock through a single toggle handshake. There it appears on two parallel outputs, together with a one-cycle strobe. Format and word length are static settings: they are taken in only while the port is disabled. After enable, any half-frame that began before enable is thrown away.

Top module: `serial_audio_rx`

## Requirements
- R1: With `fmt_sel` = 0 (I²S), the first data bit (MSB) is the one sampled on the second rising bit-clock edge after a frame-clock change, and frame clock low carries the left channel.
- R2: With `fmt_sel` = 1 (Left-Justified), the MSB is sampled on the first rising edge after a frame-clock change, and frame clock high carries the left channel.
- R3: With `fmt_sel` = 2 (Right-Justified), the word is the last N bits sampled before the next frame-clock change, with the LSB on the final one. Frame clock high carries the left channel.
- R4: The word length N is taken from `word_len`. A value of 0, or any value above `WORD_W`, means `WORD_W`. The sample sits in output bits [N-1:0], with the MSB received first and all higher bits zero.
- R5: In I²S and Left-Justified framing, bits that follow the first N of a half-frame have no effect on the sample.
- R6: A half-frame with fewer than N bits yields its received bits as the upper part of the N-bit word, with zeros in the missing LSBs.
- R7: Each completed frame, left half followed by right half, produces exactly one `sample_valid` pulse, one system clock long, after the right half ends. The outputs hold their values between pulses.
- R8: `fmt_sel` and `word_len` are taken only while `enable` is low. Changing them while enabled has no effect.
- R9: After `enable` rises, a half-frame that began before enable is discarded. A pair is only delivered for a left half followed by a right half that were both fully received.
- R10: After reset both sample outputs are zero and `sample_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial bit clock, data sampled on its rising edge |
| sclk_rst_n | input | 1 | Active-low asynchronous reset, bit-clock domain |
| lrck | input | 1 | Frame clock, one level per channel |
| sdin | input | 1 | Serial data, MSB first |
| enable | input | 1 | Port enable; settings are taken while low |
| fmt_sel | input | 2 | 0 I²S, 1 Left-Justified, 2 Right-Justified |
| word_len | input | $clog2(WORD_W+1) | Sample word length N |
| sys_clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Active-low asynchronous reset, system domain |
| left_out | output | WORD_W | Left sample of the last delivered pair |
| right_out | output | WORD_W | Right sample of the last delivered pair |
| sample_valid | output | 1 | One-cycle strobe marking a new pair |

## Verification
The bench fills the data slots that fall outside the word with ones. A receiver that keeps shifting past N in Left-Justified mode, or that takes the first bits instead of the last in Right-Justified mode, therefore returns corrupted samples.

The I²S runs send the previous word's LSB in the first slot after each frame-clock change. A missing one-bit delay shows up as every sample shifted by one bit, and the wrong frame-clock polarity shows up as left and right swapped.

Half-frames shorter than the word check the zero padding, which fails if the short word is left right-aligned. A format change while enabled, and an enable raised in the middle of a left half, check that the settings are held and that the partial frame produces no pair. A receiver that got these wrong would show extra or misaligned pairs.

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
  parameter int WORD_W = 24,
  localparam int LEN_W = $clog2(WORD_W + 1)
) (
  input  logic              sclk,
  input  logic              sclk_rst_n,
  input  logic              lrck,
  input  logic              sdin,
  input  logic              enable,
  input  logic [1:0]        fmt_sel,
  input  logic [LEN_W-1:0]  word_len,
  input  logic              sys_clk,
  input  logic              sys_rst_n,
  output logic [WORD_W-1:0] left_out,
  output logic [WORD_W-1:0] right_out,
  output logic              sample_valid
);

  localparam logic [LEN_W-1:0] FULL = LEN_W'(WORD_W);

  logic              lr_d1, lr_d2;
  logic [1:0]        fmt_q;
  logic [LEN_W-1:0]  len_q, cnt;
  logic              seen, left_ok, tog;
  logic [WORD_W-1:0] sh, left_hold, pair_l, pair_r;
  logic [2:0]        sync;

  wire is_i2s = (fmt_q == 2'd0);
  wire is_rj  = (fmt_q == 2'd2);

  // I2S runs on a one-bit delayed view of the frame clock
  wire cur_lr   = is_i2s ? lr_d1 : lrck;
  wire prv_lr   = is_i2s ? lr_d2 : lr_d1;
  wire start    = cur_lr != prv_lr;
  wire prv_left = is_i2s ? !prv_lr : prv_lr;

  wire [WORD_W-1:0] mask = {WORD_W{1'b1}} >> (FULL - len_q);
  wire [WORD_W-1:0] word = ((cnt >= len_q) ? sh : (sh << (len_q - cnt))) & mask;

  always_ff @(posedge sclk or negedge sclk_rst_n) begin
    if (!sclk_rst_n) begin
      lr_d1     <= 1'b0;
      lr_d2     <= 1'b0;
      fmt_q     <= 2'd0;
      len_q     <= FULL;
      cnt       <= '0;
      sh        <= '0;
      seen      <= 1'b0;
      left_ok   <= 1'b0;
      left_hold <= '0;
      pair_l    <= '0;
      pair_r    <= '0;
      tog       <= 1'b0;
    end else begin
      lr_d1 <= lrck;
      lr_d2 <= lr_d1;
      if (!enable) begin
        fmt_q   <= fmt_sel;
        len_q   <= (word_len == '0 || word_len > FULL) ? FULL : word_len;
        seen    <= 1'b0;
        left_ok <= 1'b0;
        cnt     <= '0;
        sh      <= '0;
      end else if (start) begin
        seen <= 1'b1;
        sh   <= {{(WORD_W-1){1'b0}}, sdin};
        cnt  <= LEN_W'(1);
        if (seen) begin
          if (prv_left) begin
            left_hold <= word;
            left_ok   <= 1'b1;
          end else if (left_ok) begin
            pair_l  <= left_hold;
            pair_r  <= word;
            tog     <= ~tog;
            left_ok <= 1'b0;
          end
        end
      end else if (is_rj || cnt < len_q) begin
        sh <= {sh[WORD_W-2:0], sdin};
        if (cnt < FULL) cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      sync         <= '0;
      sample_valid <= 1'b0;
      left_out     <= '0;
      right_out    <= '0;
    end else begin
      sync         <= {sync[1:0], tog};
      sample_valid <= sync[2] ^ sync[1];
      if (sync[2] ^ sync[1]) begin
        left_out  <= pair_l;
        right_out <= pair_r;
      end
    end
  end

  // R9
  pair_needs_left_chk: assert property (@(posedge sclk) disable iff (!sclk_rst_n)
    (tog != $past(tog)) |-> $past(left_ok));

  // R8
  fmt_hold_chk: assert property (@(posedge sclk) disable iff (!sclk_rst_n)
    $past(enable) |-> ($stable(fmt_q) && $stable(len_q)));

  // R9
  idle_no_pair_chk: assert property (@(posedge sclk) disable iff (!sclk_rst_n)
    !$past(enable) |-> $stable(tog));

  // R7
  valid_pulse_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    sample_valid |=> !sample_valid);

  // R7
  out_hold_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    !sample_valid |-> ($stable(left_out) && $stable(right_out)));

endmodule

// File: tb/serial_audio_rx_tb_top.sv
`timescale 1ns/1ps
module serial_audio_rx_tb_top;
  localparam int WW = 24;
  localparam int LW = $clog2(WW + 1);

  logic sys_clk = 1'b0, sclk = 1'b0;
  logic sys_rst_n = 1'b0, sclk_rst_n = 1'b0;
  logic lrck = 1'b0, sdin = 1'b0, enable = 1'b0;
  logic [1:0] fmt_sel = 2'd0;
  logic [LW-1:0] word_len = '0;
  logic [WW-1:0] left_out, right_out;
  logic sample_valid;

  always #10  sys_clk = ~sys_clk;
  always #100 sclk = ~sclk;

  serial_audio_rx #(.WORD_W(WW)) dut_i (
    .sclk(sclk), .sclk_rst_n(sclk_rst_n), .lrck(lrck), .sdin(sdin),
    .enable(enable), .fmt_sel(fmt_sel), .word_len(word_len),
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n),
    .left_out(left_out), .right_out(right_out), .sample_valid(sample_valid));

  int checks = 0, fails = 0, ngot = 0, cur_fmt = 0;
  logic pend = 1'b0, vprev = 1'b0;
  logic [WW-1:0] got_l [16];
  logic [WW-1:0] got_r [16];
  logic [31:0] exp_l [16];
  logic [31:0] exp_r [16];

  always @(negedge sys_clk) begin
    if (sample_valid) begin
      if (ngot < 16) begin
        got_l[ngot] = left_out;
        got_r[ngot] = right_out;
      end
      ngot++;
    end
    if (vprev) begin
      checks++;
      if (sample_valid) begin
        fails++;
        $display("FAIL R7 strobe width: actual 2+ cycles expected 1");
      end
    end
    vprev = sample_valid;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] msk(input int n);
    return (32'h1 << n) - 32'h1;
  endfunction

  task automatic send_bit(input logic lvl, input logic b);
    @(negedge sclk);
    lrck = lvl;
    if (cur_fmt == 0) begin
      sdin = pend;
      pend = b;
    end else sdin = b;
  endtask

  task automatic half(input logic lvl, input int bits, input logic [31:0] w, input int n);
    for (int p = 0; p < bits; p++) begin
      int idx;
      logic b;
      if (cur_fmt == 2) begin
        idx = bits - 1 - p;
        b = (idx < n) ? w[idx] : 1'b1;
      end else begin
        b = (p < n) ? w[n-1-p] : 1'b1;
      end
      send_bit(lvl, b);
    end
  endtask

  function automatic logic [31:0] expect_word(input int fmt, input int bits, input logic [31:0] w, input int n);
    if (bits >= n) return w & msk(n);
    if (fmt == 2) return (w & msk(bits)) << (n - bits);
    return ((w & msk(n)) >> (n - bits)) << (n - bits);
  endfunction

  task automatic run(input int fmt, input int len_in, input int n, input int bits,
                     input int nf, input int seed, input bit mid, input string tag);
    logic lft;
    lft = (fmt == 0) ? 1'b0 : 1'b1;
    @(negedge sclk);
    enable = 1'b0;
    fmt_sel = 2'(fmt);
    word_len = LW'(len_in);
    cur_fmt = fmt;
    repeat (4) send_bit(~lft, 1'b0);
    enable = 1'b1;
    repeat (3) send_bit(~lft, 1'b0);
    ngot = 0;
    if (mid) begin
      fmt_sel = 2'd0;
      word_len = LW'(8);
    end
    for (int f = 0; f < nf; f++) begin
      logic [31:0] l, r;
      l = (32'h00A5C3E1 * (f + 3) + 32'h00013579 * seed) & msk(n);
      r = (32'h005A3C1F * (f + 5) ^ 32'h00F0F0F0 ^ seed) & msk(n);
      exp_l[f] = expect_word(fmt, bits, l, n);
      exp_r[f] = expect_word(fmt, bits, r, n);
      half(lft, bits, l, n);
      half(~lft, bits, r, n);
    end
    half(lft, 4, 32'h0, n);
    repeat (4) @(negedge sclk);
    check({tag, " pair count"}, 32'(ngot), 32'(nf));
    for (int f = 0; f < nf && f < 16; f++) begin
      check({tag, " left"}, 32'(got_l[f]), exp_l[f]);
      check({tag, " right"}, 32'(got_r[f]), exp_r[f]);
    end
  endtask

  task automatic partial_enable();
    logic [31:0] l, r;
    l = 32'h0000BEEF;
    r = 32'h00001234;
    @(negedge sclk);
    enable = 1'b0;
    fmt_sel = 2'd1;
    word_len = LW'(16);
    cur_fmt = 1;
    repeat (3) send_bit(1'b1, 1'b0);
    enable = 1'b1;
    repeat (5) send_bit(1'b1, 1'b1);
    ngot = 0;
    half(1'b0, 16, 32'h0000AAAA, 16);
    half(1'b1, 16, l, 16);
    half(1'b0, 16, r, 16);
    half(1'b1, 4, 32'h0, 16);
    repeat (4) @(negedge sclk);
    check("R9 pairs after mid-frame enable", 32'(ngot), 32'd1);
    check("R9 left", 32'(got_l[0]), l);
    check("R9 right", 32'(got_r[0]), r);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge sclk);
    sys_rst_n = 1'b1;
    sclk_rst_n = 1'b1;
    repeat (2) @(negedge sclk);
    // R10
    check("R10 left after reset", 32'(left_out), 32'h0);
    check("R10 right after reset", 32'(right_out), 32'h0);
    check("R10 valid after reset", 32'(sample_valid), 32'h0);
    run(0, 16, 16, 16, 2, 1, 1'b0, "R1 i2s");
    run(1, 24, 24, 32, 2, 2, 1'b0, "R2 R5 lj");
    run(2, 16, 16, 32, 2, 3, 1'b0, "R3 rj");
    run(1, 24, 24, 16, 1, 4, 1'b0, "R6 lj short");
    run(2, 24, 24, 16, 1, 5, 1'b0, "R6 rj short");
    run(1, 0, 24, 24, 1, 6, 1'b0, "R4 len zero");
    run(0, 8, 8, 32, 1, 7, 1'b0, "R4 R5 i2s len8");
    run(1, 16, 16, 16, 2, 8, 1'b1, "R8 change while enabled");
    partial_enable();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule